// File: doc/BRIEF.md
# One-Time-Programmable Byte Store with Pin-Level Mode Control

This block models a byte-wide one-time-programmable memory as a chip would see it from its pins, but inside one synchronous clock domain. Every input is sampled on the system clock. Three control inputs are an active-low chip select, an active-low output enable and a program-supply flag. An identifier flag stands in for the raised voltage on one address line. From these inputs the block picks one of seven modes: standby, read, output off, program, program inhibit, identifier readout and program verify.

The data bus is split into an input byte and an output byte. A separate output-enable tells the surrounding logic when the output byte may drive a shared bus. Access latency is modelled by counters. Data appears a parameterised number of clocks after chip select falls, or after the address settles. When chip select and the address have both been stable for long enough, data appears a shorter parameterised number of clocks after output enable falls.

Programming follows the physics of the cell: a write can only turn ones into zeros, so the stored value becomes the old value ANDed with the new one. A test-only erase input sweeps the whole array back to all ones, one byte per clock. The identifier flag replaces array data with two fixed bytes, and address bit 0 selects which of the two is returned.

Top module: `prom_pin_model`

## Requirements
- R1: After reset, dq_oe, data_valid and erase_busy are all 0 and dq_out is 8'h00.
- R2: With cen_n=0, oe_n=0, vpp_hi=0 and id_sel=0 held and the address stable, the block drives the byte stored at addr on dq_out with dq_oe=1.
- R3: With cen_n=0, oe_n=1 and vpp_hi=0, dq_oe is 0 and dq_out is 8'h00 (output off).
- R4: While cen_n=1, dq_oe is 0 whatever oe_n and vpp_hi are (standby / inhibit).
- R5: With vpp_hi=1 and oe_n=1, each clock at which cen_n is sampled low after having been sampled high replaces the byte at addr with (old AND dq_in), exactly once per pulse. While cen_n stays high the array is unchanged and dq_oe stays 0.
- R6: With id_sel=1, vpp_hi=0, cen_n=0 and oe_n=0, the array is ignored: dq_out is 8'h20 when addr[0]=0 and 8'h3D when addr[0]=1.
- R7: When chip select, the address and output enable all become active at the same clock, dq_oe first reads 1 after exactly CE_LAT rising edges. When chip select and the address have been stable long enough, dq_oe first reads 1 exactly OE_LAT edges after oe_n is first sampled low.
- R8: With vpp_hi=1, cen_n=0 and oe_n=0 (verify), the stored byte is driven after CE_LAT edges, and no write takes place.
- R9: data_valid and dq_oe drop at the first edge that samples cen_n high, oe_n high, or a changed addr, id_sel or vpp_hi value.
- R10: A pulse on erase_req holds erase_busy high for 2**ADDR_W clocks and sets every byte to 8'hFF. dq_oe stays 0 while erase_busy is 1, and program writes are ignored during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Active-low chip select; a falling pulse programs when vpp_hi is set |
| oe_n | input | 1 | Active-low output enable |
| vpp_hi | input | 1 | Program-supply flag |
| id_sel | input | 1 | Identifier readout flag (high-voltage address line) |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Byte to program |
| erase_req | input | 1 | Test-only request to set the whole array to ones |
| dq_out | output | 8 | Read data; 8'h00 when not driving |
| dq_oe | output | 1 | Output byte is driving the bus |
| data_valid | output | 1 | Read data has met its access latency |
| erase_busy | output | 1 | Erase sweep in progress |

## Verification
The bench builds the block with ADDR_W=6, CE_LAT=5 and OE_LAT=3. The 64-byte array lets the bench run repeated full erase sweeps and random programming that hits the same bytes many times, so the AND accumulation rule is exercised on real collisions. The short, unequal latencies let directed cases land exactly on both edges of each access window: the chip-select window, the output-enable window and the address-change window.

// File: rtl/prom_pkg.sv
package prom_pkg;

  localparam int DATA_W = 8;

  localparam logic [DATA_W-1:0] ID_BYTE_EVEN = 8'h20;
  localparam logic [DATA_W-1:0] ID_BYTE_ODD  = 8'h3D;

  typedef enum logic [2:0] {
    PM_STANDBY,
    PM_READ,
    PM_OUT_OFF,
    PM_PROGRAM,
    PM_INHIBIT,
    PM_IDENT,
    PM_VERIFY
  } prom_mode_e;

  // Modes in which the output byte may be driven
  function automatic logic mode_drives(prom_mode_e m);
    return (m == PM_READ) || (m == PM_IDENT) || (m == PM_VERIFY);
  endfunction

endpackage

// File: rtl/prom_mode_decode.sv
module prom_mode_decode
  import prom_pkg::*;
(
  input  logic       cen_n,
  input  logic       oe_n,
  input  logic       vpp_hi,
  input  logic       id_sel,
  output prom_mode_e mode
);

  always_comb begin
    if (cen_n) begin
      mode = vpp_hi ? PM_INHIBIT : PM_STANDBY;
    end else if (vpp_hi) begin
      mode = oe_n ? PM_PROGRAM : PM_VERIFY;
    end else if (oe_n) begin
      mode = PM_OUT_OFF;
    end else begin
      mode = id_sel ? PM_IDENT : PM_READ;
    end
  end

endmodule

// File: rtl/prom_access_timer.sv
module prom_access_timer #(
  parameter int CE_LAT = 45,
  parameter int OE_LAT = 25,
  parameter int KEY_W  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cen_n,
  input  logic             oe_n,
  input  logic [KEY_W-1:0] key,
  output logic             ready
);

  localparam int CNT_W = $clog2(CE_LAT + 1);
  localparam logic [CNT_W-1:0] CE_TOP = CNT_W'(CE_LAT);
  localparam logic [CNT_W-1:0] OE_TOP = CNT_W'(OE_LAT);

  logic [CNT_W-1:0] ce_cnt, ce_cnt_d;
  logic [CNT_W-1:0] oe_cnt, oe_cnt_d;
  logic [CNT_W-1:0] ad_cnt, ad_cnt_d;
  logic [KEY_W-1:0] key_q;
  logic             key_moved;

  function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] c);
    return (c == CE_TOP) ? c : c + 1'b1;
  endfunction

  assign key_moved = (key != key_q);

  always_comb begin
    ce_cnt_d = cen_n ? '0 : sat_inc(ce_cnt);
    oe_cnt_d = oe_n  ? '0 : sat_inc(oe_cnt);
    ad_cnt_d = key_moved ? CNT_W'(1) : sat_inc(ad_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_cnt <= '0;
      oe_cnt <= '0;
      ad_cnt <= '0;
      key_q  <= '0;
    end else begin
      ce_cnt <= ce_cnt_d;
      oe_cnt <= oe_cnt_d;
      ad_cnt <= ad_cnt_d;
      key_q  <= key;
    end
  end

  assign ready = (ce_cnt == CE_TOP) && (oe_cnt >= OE_TOP) && (ad_cnt == CE_TOP);

endmodule

// File: rtl/prom_array.sv
module prom_array
  import prom_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              erase_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] ptr, ptr_d;
  logic              busy_d;
  logic              ptr_en;
  logic              cell_en;
  logic [ADDR_W-1:0] cell_addr;
  logic [DATA_W-1:0] cell_val;

  // Sweep control
  always_comb begin
    busy_d = busy;
    ptr_d  = ptr;
    ptr_en = 1'b0;
    if (busy) begin
      busy_d = (ptr != LAST);
      ptr_d  = ptr + 1'b1;
      ptr_en = 1'b1;
    end else if (erase_req) begin
      busy_d = 1'b1;
      ptr_d  = '0;
      ptr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr  <= '0;
    end else begin
      busy <= busy_d;
      if (ptr_en) ptr <= ptr_d;
    end
  end

  // Cell update: erase sets all ones, programming can only clear bits
  always_comb begin
    if (busy) begin
      cell_en   = 1'b1;
      cell_addr = ptr;
      cell_val  = '1;
    end else begin
      cell_en   = wr_en;
      cell_addr = wr_addr;
      cell_val  = mem[wr_addr] & wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (cell_en) mem[cell_addr] <= cell_val;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/prom_pin_model.sv
module prom_pin_model
  import prom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int CE_LAT = 45,
  parameter int OE_LAT = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              id_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  input  logic              erase_req,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic              data_valid,
  output logic              erase_busy
);

  localparam int KEY_W = ADDR_W + 2;

  prom_mode_e        mode_live;
  prom_mode_e        mode_q;
  logic              cen_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_en;
  logic              timer_ready;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] id_byte;

  prom_mode_decode u_decode (
    .cen_n  (cen_n),
    .oe_n   (oe_n),
    .vpp_hi (vpp_hi),
    .id_sel (id_sel),
    .mode   (mode_live)
  );

  prom_access_timer #(
    .CE_LAT (CE_LAT),
    .OE_LAT (OE_LAT),
    .KEY_W  (KEY_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .cen_n (cen_n),
    .oe_n  (oe_n),
    .key   ({vpp_hi, id_sel, addr}),
    .ready (timer_ready)
  );

  // One write per falling chip-select pulse in program mode
  assign wr_en = (mode_live == PM_PROGRAM) && cen_q && !erase_busy;

  prom_array #(
    .ADDR_W (ADDR_W)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (addr),
    .wr_data   (dq_in),
    .erase_req (erase_req),
    .rd_addr   (addr_q),
    .rd_data   (rd_data),
    .busy      (erase_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cen_q  <= 1'b1;
      mode_q <= PM_STANDBY;
      addr_q <= '0;
    end else begin
      cen_q  <= cen_n;
      mode_q <= mode_live;
      addr_q <= addr;
    end
  end

  assign id_byte    = addr_q[0] ? ID_BYTE_ODD : ID_BYTE_EVEN;
  assign data_valid = timer_ready && mode_drives(mode_q) && !erase_busy;
  assign dq_oe      = data_valid;

  always_comb begin
    if (!data_valid)            dq_out = '0;
    else if (mode_q == PM_IDENT) dq_out = id_byte;
    else                        dq_out = rd_data;
  end

endmodule

// File: rtl/prom_pin_model_chk.sv
module prom_pin_model_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cen_n,
  input logic              oe_n,
  input logic              vpp_hi,
  input logic              id_sel,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        dq_out,
  input logic              dq_oe,
  input logic              data_valid,
  input logic              erase_busy
);

  // R4
  standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> !dq_oe);

  // R3
  out_off_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && oe_n && !vpp_hi) |=> (!dq_oe && dq_out == 8'h00));

  // R9
  addr_move_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != $past(addr)) |=> !data_valid);

  // R10
  erase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |-> !dq_oe);

  // R6
  ident_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(id_sel) && !$past(vpp_hi) && !$past(addr[0])) |-> dq_out == 8'h20);

  // R6
  ident_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(id_sel) && !$past(vpp_hi) && $past(addr[0])) |-> dq_out == 8'h3D);

endmodule

bind prom_pin_model prom_pin_model_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cen_n      (cen_n),
  .oe_n       (oe_n),
  .vpp_hi     (vpp_hi),
  .id_sel     (id_sel),
  .addr       (addr),
  .dq_out     (dq_out),
  .dq_oe      (dq_oe),
  .data_valid (data_valid),
  .erase_busy (erase_busy)
);

// File: tb/prom_pin_model_test.sv
module prom_pin_model_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int CEL   = 5;
  localparam int OEL   = 3;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cen_n, oe_n, vpp_hi, id_sel, erase_req;
  logic [AW-1:0] addr;
  logic [7:0]    dq_in;
  logic [7:0]    dq_out;
  logic          dq_oe, data_valid, erase_busy;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  prom_pin_model #(.ADDR_W(AW), .CE_LAT(CEL), .OE_LAT(OEL)) uut (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .id_sel(id_sel), .addr(addr), .dq_in(dq_in), .erase_req(erase_req),
    .dq_out(dq_out), .dq_oe(dq_oe), .data_valid(data_valid), .erase_busy(erase_busy)
  );

  function automatic logic [7:0] ident_byte(logic a0);
    return a0 ? 8'h3D : 8'h20;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_idle();
    cen_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b0; id_sel = 1'b0;
  endtask

  // Full access from standby: all controls go active together
  task automatic access(input logic [AW-1:0] a, input logic ident, input logic vpp,
                        input logic [7:0] exp, input string tag);
    addr = a; id_sel = ident; vpp_hi = vpp; oe_n = 1'b0; cen_n = 1'b0;
    repeat (CEL - 1) tick();
    chk(!dq_oe, {tag, " R7 early"}, dq_oe, 0);
    tick();
    chk(dq_oe && dq_out == exp, tag, {dq_oe, dq_out}, {1'b1, exp});
    cen_n = 1'b1;
    tick();
    chk(!dq_oe && !data_valid, "R4 R9 deselect", dq_oe, 0);
    go_idle();
    tick();
  endtask

  task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d);
    vpp_hi = 1'b1; oe_n = 1'b1; cen_n = 1'b1; addr = a; dq_in = d;
    tick();
    cen_n = 1'b0;
    tick();
    chk(!dq_oe, "R5 no drive in program", dq_oe, 0);
    tick();
    cen_n = 1'b1;
    tick();
    model[a] = model[a] & d;
    go_idle();
  endtask

  task automatic erase_all();
    int cnt;
    erase_req = 1'b1;
    tick();
    erase_req = 1'b0;
    cnt = erase_busy ? 1 : 0;
    // read attempt during the sweep
    cen_n = 1'b0; oe_n = 1'b0; addr = '0;
    while (erase_busy) begin
      tick();
      if (erase_busy) begin
        cnt++;
        if (!dq_oe == 1'b0) chk(1'b0, "R10 drive while busy", dq_oe, 0);
      end
    end
    chk(cnt == DEPTH, "R10 busy length", cnt, DEPTH);
    go_idle();
    tick();
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    logic [7:0]    d;
    void'($urandom(32'h1A2B3C4D));
    rst_n = 1'b0; erase_req = 1'b0; dq_in = '0; addr = '0;
    go_idle();
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(!dq_oe && !data_valid && !erase_busy && dq_out == 8'h00, "R1 reset",
        {dq_oe, data_valid, erase_busy, dq_out}, 0);

    // R10 erase sweep, then blank reads
    erase_all();
    access(6'd0, 1'b0, 1'b0, 8'hFF, "R10 blank byte 0");
    access(6'(DEPTH - 1), 1'b0, 1'b0, 8'hFF, "R10 blank last byte");

    // R5 program twice to the same byte: AND accumulates
    program_byte(6'd9, 8'hF0);
    program_byte(6'd9, 8'h3C);
    access(6'd9, 1'b0, 1'b0, 8'h30, "R5 and-accumulate");
    program_byte(6'd9, 8'hFF);
    access(6'd9, 1'b0, 1'b0, 8'h30, "R5 ones cannot be restored");

    // R5 inhibit: supply raised, chip select held high
    vpp_hi = 1'b1; oe_n = 1'b1; dq_in = 8'h00;
    for (int i = 0; i < 4; i++) begin
      addr = 6'(i + 20);
      tick();
      chk(!dq_oe, "R4 inhibit hiz", dq_oe, 0);
    end
    go_idle();
    access(6'd21, 1'b0, 1'b0, model[21], "R5 inhibit leaves byte");

    // R8 verify straight after programming
    program_byte(6'd33, 8'hA5);
    access(6'd33, 1'b0, 1'b1, model[33], "R8 verify");
    access(6'd33, 1'b0, 1'b0, 8'hA5, "R8 verify did not write");

    // R6 identifier bytes ignore the array
    program_byte(6'd0, 8'h00);
    access(6'd0, 1'b1, 1'b0, ident_byte(1'b0), "R6 even id byte");
    access(6'd1, 1'b1, 1'b0, ident_byte(1'b1), "R6 odd id byte");

    // R4 standby with output enable low
    cen_n = 1'b1; oe_n = 1'b0; addr = 6'd9;
    repeat (CEL + 1) tick();
    chk(!dq_oe, "R4 standby oe low", dq_oe, 0);

    // R3 output off, then R7 output-enable latency
    go_idle();
    cen_n = 1'b0; addr = 6'd9;
    repeat (CEL + 2) tick();
    chk(!dq_oe && dq_out == 8'h00, "R3 output off", {dq_oe, dq_out}, 0);
    oe_n = 1'b0;
    repeat (OEL - 1) tick();
    chk(!dq_oe, "R7 oe early", dq_oe, 0);
    tick();
    chk(dq_oe && dq_out == model[9], "R7 oe latency", dq_out, model[9]);

    // R9 output enable rises
    oe_n = 1'b1;
    tick();
    chk(!data_valid, "R9 oe high drop", data_valid, 0);
    oe_n = 1'b0;
    repeat (OEL) tick();
    chk(dq_oe && dq_out == model[9], "R2 read back", dq_out, model[9]);

    // R9 address change drops valid, R2 new byte after CE_LAT
    addr = 6'd33;
    tick();
    chk(!data_valid, "R9 address move drop", data_valid, 0);
    repeat (CEL - 1) tick();
    chk(dq_oe && dq_out == model[33], "R2 after address move", dq_out, model[33]);
    go_idle();
    tick();

    // R2 R5 constrained random programs and reads
    for (int i = 0; i < 40; i++) begin
      a = 6'($urandom_range(0, DEPTH - 1));
      d = 8'($urandom);
      if ($urandom_range(0, 1) == 1) program_byte(a, d | 8'($urandom));
      access(a, 1'b0, 1'b0, model[a], "R2 random read");
    end

    // R10 second erase restores all ones
    erase_all();
    access(6'd9, 1'b0, 1'b0, 8'hFF, "R10 re-erased byte");
    access(6'd33, 1'b0, 1'b0, 8'hFF, "R10 re-erased byte 33");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule